// File: doc/BRIEF.md
# Synchronous FIFO with Column-Parity Fault Detection

A single-clock FIFO of configurable word width and depth, with push and pop strobes and full and empty flags. Alongside the storage sits an inexpensive checker. One register, exactly one data word wide, holds a running XOR. Every accepted write folds the incoming word into it. Every accepted read folds the word actually leaving the array into it.

When the memory holds data correctly, each word is folded in twice and cancels out. So whenever the FIFO is empty, the register is back at zero. A nonzero value seen while the FIFO is empty means some stored bit changed while it sat in the array, and a sticky fault flag is raised. Because of this, a corruption is only reported after the FIFO next drains, so detection latency depends on occupancy.

A clear input drops the fault flag and zeroes the register. A debug port can flip bits of a stored word, so that upsets can be emulated.

Top module: `colpar_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `fault` is 0.
- R2: Words leave in the order they were accepted. `pop_data` combinationally shows the oldest stored word whenever `empty` is 0.
- R3: `full` is 1 exactly when DEPTH words are stored. A push while full is ignored unless a pop is accepted in the same cycle.
- R4: A pop while empty is ignored. The FIFO stays empty and the parity register is unchanged, so no fault follows from it.
- R5: A push and a pop accepted in the same cycle leave the occupancy unchanged, and both words are folded into the parity register.
- R6: On the clock edge after a cycle in which the FIFO is empty and the parity register is nonzero, `fault` becomes 1.
- R7: `fault` stays 1 until `fault_clr` is sampled high. That edge sets `fault` to 0 and zeroes the parity register, and `fault_clr` takes priority over setting. It is meant to be used while the FIFO is empty.
- R8: Under any push/pop traffic with no injected corruption, `fault` stays 0.
- R9: With `inj_en` high at an edge, the word in slot `inj_addr` is XORed with `inj_mask`. A write to the same slot in that edge wins. Slots are written in order starting at slot 0 after reset, wrapping after DEPTH-1, so the n-th accepted push (counting from 0) lands in slot n mod DEPTH. The corrupted value is what `pop_data` shows.
- R10: A corruption is not reported while the FIFO is nonempty. `fault` stays 0 until the FIFO has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Write strobe |
| push_data | input | WIDTH | Word to write |
| full | output | 1 | DEPTH words stored |
| pop | input | 1 | Read strobe |
| pop_data | output | WIDTH | Oldest stored word |
| empty | output | 1 | No words stored |
| fault_clr | input | 1 | Clear fault flag and parity register |
| fault | output | 1 | Sticky corruption indication |
| inj_en | input | 1 | Debug: apply bit flip |
| inj_addr | input | $clog2(DEPTH) | Debug: slot to corrupt |
| inj_mask | input | WIDTH | Debug: bits to flip |

## Verification
The hardest situation to reach is a fault that stays latent while the FIFO holds data and only surfaces when the FIFO drains. Reaching it needs the bench to know which physical slot holds which queued word. The bench therefore counts accepted pushes to find the slot of a chosen queue entry, flips bits there through the debug port in a cycle without traffic, and then keeps checking that `fault` stays low through the drain until exactly one edge after emptiness. Random traffic, with occasional injections and clears issued only while empty, then mixes this with simultaneous push/pop and full/empty boundaries.

// File: rtl/colpar_pkg.sv
package colpar_pkg;

    typedef enum logic [1:0] {
        XFER_NONE = 2'd0,
        XFER_WR   = 2'd1,
        XFER_RD   = 2'd2,
        XFER_BOTH = 2'd3
    } xfer_e;

    function automatic xfer_e classify(input logic wr_ok, input logic rd_ok);
        return xfer_e'({rd_ok, wr_ok});
    endfunction

endpackage

// File: rtl/colpar_ctrl.sv
module colpar_ctrl
    import colpar_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_q, st_d;
    xfer_e xfer;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == CW'(DEPTH));
    assign rd_ok   = pop && !empty;
    assign wr_ok   = push && (!full || rd_ok);
    assign wr_addr = st_q.wr;
    assign rd_addr = st_q.rd;
    assign xfer    = classify(wr_ok, rd_ok);

    always_comb begin
        st_d = st_q;
        unique case (xfer)
            XFER_WR: begin
                st_d.wr  = bump(st_q.wr);
                st_d.cnt = st_q.cnt + 1'b1;
            end
            XFER_RD: begin
                st_d.rd  = bump(st_q.rd);
                st_d.cnt = st_q.cnt - 1'b1;
            end
            XFER_BOTH: begin
                st_d.wr = bump(st_q.wr);
                st_d.rd = bump(st_q.rd);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    // R3
    full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop |=> full);
    // R4
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push |=> empty);
    // R5
    both_keep_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop && !empty |=> $stable(st_q.cnt));
endmodule

// File: rtl/colpar_mem.sv
module colpar_mem #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic             inj_en,
    input  logic [AW-1:0]    inj_addr,
    input  logic [WIDTH-1:0] inj_mask
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] mem_d [DEPTH];

    assign rd_data = mem_q[rd_addr];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (inj_en && inj_addr == AW'(i)) mem_d[i] = mem_q[i] ^ inj_mask;
            if (wr_en && wr_addr == AW'(i))   mem_d[i] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !(inj_en && inj_addr == wr_addr) && rd_addr == wr_addr
        |=> rd_data == $past(wr_data) || $changed(rd_addr));
endmodule

// File: rtl/colpar_mon.sv
module colpar_mon #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_word,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] rd_word,
    input  logic             empty,
    input  logic             clr,
    output logic             fault
);
    typedef struct packed {
        logic [WIDTH-1:0] par;
        logic             flag;
    } mon_t;

    mon_t m_q, m_d;

    always_comb begin
        m_d = m_q;
        if (wr_en) m_d.par = m_d.par ^ wr_word;
        if (rd_en) m_d.par = m_d.par ^ rd_word;
        m_d.flag = m_q.flag | (empty && (m_q.par != '0));
        if (clr) begin
            m_d.par  = '0;
            m_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign fault = m_q.flag;

    // R7
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault && !clr |=> fault);
    // R7
    clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !fault && m_q.par == '0);
    // R10
    fault_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(empty));
    // R4
    idle_par_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && !rd_en && !clr |=> $stable(m_q.par));
endmodule

// File: rtl/colpar_fifo.sv
module colpar_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    output logic             full,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             empty,
    input  logic             fault_clr,
    output logic             fault,
    input  logic             inj_en,
    input  logic [AW-1:0]    inj_addr,
    input  logic [WIDTH-1:0] inj_mask
);
    logic          wr_ok, rd_ok;
    logic [AW-1:0] wr_addr, rd_addr;

    colpar_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .wr_ok(wr_ok), .rd_ok(rd_ok), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .full(full), .empty(empty)
    );

    colpar_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_addr(wr_addr),
        .wr_data(push_data), .rd_addr(rd_addr), .rd_data(pop_data),
        .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask)
    );

    colpar_mon #(.WIDTH(WIDTH)) u_mon (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_word(push_data),
        .rd_en(rd_ok), .rd_word(pop_data), .empty(empty), .clr(fault_clr),
        .fault(fault)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> empty && !full && !fault);
endmodule

// File: tb/test_colpar_fifo.sv
module test_colpar_fifo;
    localparam int W = 8;
    localparam int D = 8;
    localparam int AW = $clog2(D);
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push = 1'b0, pop = 1'b0, fault_clr = 1'b0, inj_en = 1'b0;
    logic [W-1:0] push_data = '0, inj_mask = '0;
    logic [AW-1:0] inj_addr = '0;
    logic full, empty, fault;
    logic [W-1:0] pop_data;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [W-1:0] mq[$];
    logic [W-1:0] acc = '0;
    int unsigned wr_cnt = 0;
    bit exp_fault = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    colpar_fifo #(.WIDTH(W), .DEPTH(D)) i_colpar_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .full(full), .pop(pop), .pop_data(pop_data), .empty(empty),
        .fault_clr(fault_clr), .fault(fault), .inj_en(inj_en),
        .inj_addr(inj_addr), .inj_mask(inj_mask)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int slot_of(input int k);
        return int'((wr_cnt - mq.size() + k) % D);
    endfunction

    // one cycle: drive at negedge, check pop_data before edge, flags after edge
    task automatic step(input bit p, input logic [W-1:0] d, input bit q,
                        input bit c, input bit ij, input int k,
                        input logic [W-1:0] m, input string tag);
        bit pok, wok, nf;
        @(negedge clk);
        push = p; push_data = d; pop = q; fault_clr = c; inj_en = ij;
        inj_addr = ij ? AW'(slot_of(k)) : '0; inj_mask = m;
        #1;
        if (mq.size() > 0) chk(pop_data == mq[0], "R2", pop_data, mq[0]);
        pok = q && mq.size() > 0;
        wok = p && (mq.size() < D || pok);
        if (c) begin nf = 0; acc = '0; end
        else nf = exp_fault | (mq.size() == 0 && acc != '0);
        @(posedge clk); #1;
        if (ij) begin mq[k] = mq[k] ^ m; acc = acc ^ m; end
        if (pok) void'(mq.pop_front());
        if (wok) begin mq.push_back(d); wr_cnt++; end
        exp_fault = nf;
        chk(empty == (mq.size() == 0), (p && pok) ? "R5" : tag, empty, mq.size() == 0);
        chk(full == (mq.size() == D), "R3", full, mq.size() == D);
        chk(fault == exp_fault, exp_fault ? "R6" : "R10", fault, exp_fault);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        chk(empty == 1'b1 && full == 1'b0 && fault == 1'b0, "R1", {empty, full, fault}, 3'b100);
        @(negedge clk) rst_n = 1'b1;

        // R3: fill, then push while full is ignored
        for (int i = 0; i < D; i++) step(1, W'(8'h10 + i), 0, 0, 0, 0, '0, "R3");
        step(1, 8'hEE, 0, 0, 0, 0, '0, "R3");
        chk(mq.size() == D, "R3", mq.size(), D);
        // R2: drain in order
        for (int i = 0; i < D; i++) step(0, '0, 1, 0, 0, 0, '0, "R2");
        // R4: pops while empty ignored, no fault follows
        for (int i = 0; i < 4; i++) step(0, '0, 1, 0, 0, 0, '0, "R4");
        chk(fault == 1'b0, "R4", fault, 0);

        // R8: random traffic without corruption
        for (int i = 0; i < 2000; i++)
            step(($urandom % 3) != 0, W'($urandom), ($urandom % 3) != 0, 0, 0, 0, '0, "R8");
        chk(fault == 1'b0, "R8", fault, 0);
        while (mq.size() > 0) step(0, '0, 1, 0, 0, 0, '0, "R8");

        // R9/R10/R6: corrupt a queued word, observe latency
        for (int i = 0; i < 4; i++) step(1, W'(8'hA0 + i), 0, 0, 0, 0, '0, "R9");
        step(0, '0, 0, 0, 1, 1, 8'h04, "R9");
        chk(mq[1] == 8'hA5, "R9", mq[1], 8'hA5);
        for (int i = 0; i < 4; i++) step(0, '0, 1, 0, 0, 0, '0, "R10");
        chk(fault == 1'b0 && empty == 1'b1, "R10", fault, 0);
        step(0, '0, 0, 0, 0, 0, '0, "R6");
        chk(fault == 1'b1, "R6", fault, 1);
        // R7: sticky through traffic, then clear
        for (int i = 0; i < 6; i++) step(i < 3, W'(i), i >= 3, 0, 0, 0, '0, "R7");
        chk(fault == 1'b1, "R7", fault, 1);
        step(0, '0, 0, 1, 0, 0, '0, "R7");
        chk(fault == 1'b0, "R7", fault, 0);
        for (int i = 0; i < 5; i++) step(0, '0, 0, 0, 0, 0, '0, "R7");

        // mixed random with occasional injections, clears only while empty
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 40);
            if (r == 0 && mq.size() > 0)
                step(0, '0, 0, 0, 1, int'($urandom % mq.size()), W'(1 << ($urandom % W)), "R9");
            else if (r == 1 && mq.size() == 0)
                step(0, '0, 0, 1, 0, 0, '0, "R7");
            else
                step(($urandom % 2) != 0, W'($urandom), ($urandom % 2) != 0, 0, 0, 0, '0, "R5");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule